// File: doc/BRIEF.md
# Run-Length Byte Encoder for a Parallel Link

This block sits on the host side of a bidirectional parallel link. It takes a plain byte stream and rewrites it as a stream of items, each carrying a flag that marks it as a command or as data. A byte that does not repeat passes through unchanged as one data item. Two or more equal bytes in a row become two items: a count command, then one copy of the byte, marked as data. The receiver expands the pair back into the run.

Both sides use a valid/ready handshake. Each input byte also carries an end-of-packet flag. A run never spans a packet boundary and never covers more than 128 bytes, so one pair stands for at most 128 bytes and the best ratio is 64:1. While the encoder is sending a closed run, it takes no input. When the output is stalled, it holds the current item unchanged.

Top module: `rle_byte_encoder`

## Requirements
- R1: A byte that differs from the bytes on both sides of it in the same packet is sent as one item with `out_cmd_o`=0 and `out_data_o` equal to the byte.
- R2: A run of N equal bytes, with 2 ≤ N ≤ 128, is sent as exactly two items: first a command (`out_cmd_o`=1) whose value is N-1, then a data item (`out_cmd_o`=0) holding the byte.
- R3: A command item holds the count in bits 6:0, and bit 7 of a command item is always 0.
- R4: A run longer than 128 bytes is split. Each full group of 128 is closed and sent as soon as it fills, and the rest starts a new run. A remainder of one byte goes out as a plain data item.
- R5: The byte accepted with `in_last_i`=1 closes the pending run. That run is fully sent before the next byte is accepted, so equal bytes in two packets are never merged into one run.
- R6: While `out_valid_o`=1 and `out_ready_i`=0, `out_valid_o`, `out_data_o` and `out_cmd_o` hold their values. `in_ready_o` is 0 whenever `out_valid_o` is 1, and no input byte is lost or repeated.
- R7: A data byte with bit 7 set (for example 0x80 or 0xFF) still goes out with `out_cmd_o`=0, both as a single byte and as the byte of a run.
- R8: While `rst_ni` is low, `out_valid_o` is 0 and `in_ready_o` is 1.
- R9: Every command item is followed directly by the data item of its run, with no other item in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Input byte ends the packet |
| in_ready_o | output | 1 | Encoder accepts the input byte |
| out_valid_o | output | 1 | Output item valid |
| out_data_o | output | 8 | Output item: count value or data byte |
| out_cmd_o | output | 1 | 1 = count command, 0 = data |
| out_ready_i | input | 1 | Receiver takes the output item |

## Verification
The stimulus is a table of segments, each a byte value with a length and an optional end of packet. It includes:
- isolated bytes next to short runs, which tells plain data apart from a two-byte run;
- bytes with the top bit set, which must never come out flagged as commands;
- equal bytes on either side of a packet end, which shows whether a flush happens or runs wrongly merge;
- runs of exactly 128, 129 and 300 bytes, which exercise the split at the limit and the one-byte remainder.

The whole stream is replayed twice: once with the output always ready, and once with a periodic stall. The second pass separates correct holding of the output from dropped or repeated items.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;
  typedef enum logic [1:0] {
    ST_ACC = 2'd0,  // taking input, run may be pending
    ST_CMD = 2'd1,  // presenting count command
    ST_DAT = 2'd2   // presenting run byte
  } enc_st_e;
endpackage

// File: rtl/rle_run_match.sv
module rle_run_match #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int MAX_RUN = 128
) (
  input  logic              run_vld_i,
  input  logic [DATA_W-1:0] run_byte_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  input  logic [DATA_W-1:0] in_byte_i,
  output logic              extend_o,
  output logic              fills_o
);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_RUN - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_RUN - 2);

  assign extend_o = run_vld_i && (in_byte_i == run_byte_i) && (run_cnt_i != MAX_CNT);
  // extending from here reaches the run limit
  assign fills_o  = (run_cnt_i == LAST_CNT);
endmodule

// File: rtl/rle_item_fmt.sv
module rle_item_fmt
  import rle_enc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  enc_st_e           st_i,
  input  logic [DATA_W-1:0] run_byte_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  output logic              valid_o,
  output logic              cmd_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    valid_o = (st_i != ST_ACC);
    cmd_o   = (st_i == ST_CMD);
    data_o  = cmd_o ? DATA_W'(run_cnt_i) : run_byte_i;
  end
endmodule

// File: rtl/rle_byte_encoder.sv
module rle_byte_encoder
  import rle_enc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_RUN = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_cmd_o,
  input  logic              out_ready_i
);
  localparam int CNT_W = $clog2(MAX_RUN);

  enc_st_e           st_q;
  logic              run_vld_q;
  logic [DATA_W-1:0] run_byte_q;
  logic [CNT_W-1:0]  run_cnt_q;
  logic              hold_vld_q;
  logic [DATA_W-1:0] hold_byte_q;
  logic              hold_last_q;

  logic extend, fills, fire_in, fire_out;

  rle_run_match #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_RUN(MAX_RUN)) i_match (
    .run_vld_i (run_vld_q),
    .run_byte_i(run_byte_q),
    .run_cnt_i (run_cnt_q),
    .in_byte_i (in_data_i),
    .extend_o  (extend),
    .fills_o   (fills)
  );

  rle_item_fmt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_fmt (
    .st_i      (st_q),
    .run_byte_i(run_byte_q),
    .run_cnt_i (run_cnt_q),
    .valid_o   (out_valid_o),
    .cmd_o     (out_cmd_o),
    .data_o    (out_data_o)
  );

  assign in_ready_o = (st_q == ST_ACC);
  assign fire_in    = in_valid_i && in_ready_o;
  assign fire_out   = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_ACC;
      run_vld_q   <= 1'b0;
      run_byte_q  <= '0;
      run_cnt_q   <= '0;
      hold_vld_q  <= 1'b0;
      hold_byte_q <= '0;
      hold_last_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ACC: if (fire_in) begin
          if (extend) begin
            run_cnt_q <= run_cnt_q + 1'b1;
            if (fills || in_last_i) st_q <= ST_CMD;  // limit reached or packet end
          end else if (!run_vld_q) begin
            run_vld_q  <= 1'b1;
            run_byte_q <= in_data_i;
            run_cnt_q  <= '0;
            if (in_last_i) st_q <= ST_DAT;
          end else begin
            // new byte breaks the run: park it, flush the old run
            hold_vld_q  <= 1'b1;
            hold_byte_q <= in_data_i;
            hold_last_q <= in_last_i;
            st_q        <= (run_cnt_q == '0) ? ST_DAT : ST_CMD;
          end
        end
        ST_CMD: if (fire_out) st_q <= ST_DAT;
        ST_DAT: if (fire_out) begin
          if (hold_vld_q) begin
            hold_vld_q <= 1'b0;
            run_vld_q  <= 1'b1;
            run_byte_q <= hold_byte_q;
            run_cnt_q  <= '0;
            st_q       <= hold_last_q ? ST_DAT : ST_ACC;
          end else begin
            run_vld_q <= 1'b0;
            st_q      <= ST_ACC;
          end
        end
        default: st_q <= ST_ACC;
      endcase
    end
  end

  a_r6_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_cmd_o));
  a_r6_no_input_while_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  a_r3_cmd_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cmd_o |-> !out_data_o[DATA_W-1]);
  a_r2_cmd_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cmd_o |-> out_data_o != '0);
  a_r4_cnt_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cmd_o |-> out_data_o < DATA_W'(MAX_RUN));
  a_r9_cmd_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_cmd_o && out_ready_i |=> out_valid_o && !out_cmd_o);
  a_r5_flush_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i |=> out_valid_o);
endmodule

// File: tb/test_rle_byte_encoder.sv
`timescale 1ns/1ps
module test_rle_byte_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_cmd;
  logic       out_ready = 1'b0;

  always #4 clk = ~clk;

  rle_byte_encoder i_rle_byte_encoder (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_cmd_o(out_cmd), .out_ready_i(out_ready)
  );

  // segment table: value, length, packet end
  localparam int NSEG = 11;
  localparam logic [7:0] SEG_VAL [NSEG] = '{8'h41, 8'h42, 8'h43, 8'h80, 8'hFF, 8'hFF,
                                            8'h00, 8'h11, 8'h22, 8'h22, 8'h33};
  localparam int SEG_LEN [NSEG] = '{1, 2, 1, 3, 1, 5, 128, 129, 300, 2, 1};
  // R5: segments 4/5 and 8/9 repeat a byte across a packet end
  // R4: 129 and 300 force splits at 128
  localparam bit SEG_END [NSEG] = '{0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 1};

  logic [8:0] stim_mem [0:1023];
  logic [8:0] exp_mem  [0:1023];
  int stim_n = 0, exp_n = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_run(input logic [7:0] v, input int n);
    if (n > 1) begin exp_mem[exp_n] = {1'b1, 8'(n - 1)}; exp_n++; end
    exp_mem[exp_n] = {1'b0, v}; exp_n++;
  endtask

  task automatic build();
    logic [7:0] cur = '0;
    int run = 0;
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < SEG_LEN[s]; k++) begin
        stim_mem[stim_n] = {(SEG_END[s] && k == SEG_LEN[s] - 1), SEG_VAL[s]};
        stim_n++;
      end
    for (int i = 0; i < stim_n; i++) begin
      if (run > 0 && stim_mem[i][7:0] == cur && run < 128) run++;
      else begin
        if (run > 0) push_run(cur, run);
        cur = stim_mem[i][7:0];
        run = 1;
      end
      if (stim_mem[i][8]) begin push_run(cur, run); run = 0; end
    end
    if (run > 0) push_run(cur, run);
  endtask

  task automatic drive_stream();
    for (int i = 0; i < stim_n; i++) begin
      in_valid = 1'b1;
      in_data  = stim_mem[i][7:0];
      in_last  = stim_mem[i][8];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic monitor(input int mode);
    int rcv = 0;
    int cyc = 0;
    bit stall = 1'b0;
    logic [8:0] held = '0;
    while (rcv < exp_n) begin
      @(negedge clk);
      cyc++;
      if (stall) chk(out_valid && {out_cmd, out_data} == held, "R6 hold", {out_valid, out_cmd, out_data}, {1'b1, held});
      if (out_valid) chk(!in_ready, "R6 in_ready", int'(in_ready), 0);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
      stall = out_valid && !out_ready;
      held  = {out_cmd, out_data};
      if (out_valid && out_ready) begin
        if (exp_mem[rcv][8]) begin
          chk({out_cmd, out_data} == exp_mem[rcv], "R2/R9 cmd", {out_cmd, out_data}, exp_mem[rcv]);
          chk(!out_data[7], "R3 msb", out_data, 0);
        end else if (exp_mem[rcv][7])
          chk({out_cmd, out_data} == exp_mem[rcv], "R7 data", {out_cmd, out_data}, exp_mem[rcv]);
        else
          chk({out_cmd, out_data} == exp_mem[rcv], "R1 data", {out_cmd, out_data}, exp_mem[rcv]);
        rcv++;
      end
    end
  endtask

  task automatic idle_check();
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R5 no extra item", int'(out_valid), 0);
    end
  endtask

  initial begin
    build();
    repeat (3) @(negedge clk);
    chk(!out_valid, "R8 out_valid", int'(out_valid), 0);
    chk(in_ready, "R8 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      drive_stream();
      monitor(0);
    join
    idle_check();
    fork
      drive_stream();
      monitor(1);  // R6 under periodic stall
    join
    idle_check();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule